// File: doc/BRIEF.md
# DMA channel address and count engine

This block is the transfer engine of a single channel in a legacy-style DMA controller. Software loads a 16-bit start offset, a 16-bit transfer count and an 8-bit page number. It can also turn on automatic reloading. The engine then presents a 24-bit physical bus address for every granted transfer. After each transfer it advances the offset by one and lowers the count by one. The count is loaded as the number of transfers minus one. Terminal count is flagged on the transfer that takes the count from 0x0000 to 0xFFFF.

The 16-bit offset wraps inside its page and never carries into the page number. As a result, one transfer run stays within a 64 KB window in byte mode or a 128 KB window in word mode. The parameter `WORD_MODE` selects word addressing. In word mode the offset is shifted left by one bit, bus bit 0 is zero, and page bit 0 is ignored.

Transfers use a valid/ready handshake. The requester raises `xfer_valid` and may hold it high for as long as it likes. The engine drives `xfer_ready` high only while the channel is unmasked. A transfer happens on each rising edge where both signals are high. `bus_addr` and `tc` refer to that transfer during the handshake cycle. When ready is low, valid is not consumed and has no effect. The valid/ready pair carries no data of its own, and neither side has to hold valid or ready high for any minimum time.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `xfer_ready` is 0 (channel masked), `residue` is 0x0000, `bus_addr` is 0 and `tc` is 0.
- R2: With `WORD_MODE`=0, `bus_addr[23:16]` equals the page and `bus_addr[15:0]` equals the current offset.
- R3: With `WORD_MODE`=1, `bus_addr[0]` is 0, `bus_addr[16:1]` equals the current offset, `bus_addr[23:17]` equals page bits 7:1, and page bit 0 has no effect. The byte residue is computed as (`residue`+1)*2.
- R4: Each handshake where `residue` is not 0x0000 increments the offset by one and decrements `residue` by one, and both changes are visible in the next cycle.
- R5: The offset wraps from 0xFFFF to 0x0000 without changing the page bits of `bus_addr`.
- R6: `tc` is 1 exactly in a handshake cycle where `residue` is 0x0000, and 0 in every other cycle.
- R7: At terminal count with auto-reload off, the offset increments, `residue` becomes 0xFFFF and the channel masks itself, so `xfer_ready` is 0 from the next cycle.
- R8: At terminal count with auto-reload on, the offset and count reload from the last values written to them, and the channel stays unmasked.
- R9: While `xfer_ready` is 0, a high `xfer_valid` has no effect on `bus_addr` or `residue`.
- R10: A configuration write with `cfg_we`=1 takes effect on the next cycle. `cfg_sel` selects the target: 0 writes the offset, 1 the count, 2 the page (`cfg_data[7:0]`), and 3 the mode (`cfg_data[0]` is auto-reload). Writing the offset or the count updates both its base copy and its current copy.
- R11: A loaded count of K yields exactly K+1 transfers before terminal count (0x0000 gives 1 transfer, 0xFFFF gives 65536).
- R12: `mask_set` masks the channel and `mask_clr` unmasks it, each from the next cycle. If both are high in the same cycle, the mask is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 offset, 1 count, 2 page, 3 mode |
| cfg_data | input | 16 | Configuration write data |
| mask_set | input | 1 | Mask the channel |
| mask_clr | input | 1 | Unmask the channel |
| xfer_valid | input | 1 | Transfer requested (granted cycle) |
| xfer_ready | output | 1 | Channel unmasked and able to transfer |
| bus_addr | output | 24 | Physical bus address of the current transfer |
| residue | output | 16 | Current count (transfers left minus one) |
| tc | output | 1 | Terminal count, high in the final transfer's handshake cycle |

## Verification
Several rules are checked by assertions on every cycle. These are the count step on each non-final handshake and the rule that `tc` only appears in a handshake cycle at count zero. They also cover self-masking after a non-reloading terminal count, the frozen state while the channel is masked, and the fixed page bits across a handshake. Only the bench scenarios can show the exact bus address mapping in each mode, with page bit 0 dropped in word mode. The same applies to the offset wrap at 0xFFFF, the reload from base values, and the K+1 transfer total for a full 0xFFFF count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    SEL_OFFSET = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_PAGE   = 2'd2,
    SEL_MODE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/dma_offset_unit.sv
module dma_offset_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] base_val,
  input  logic         step,
  input  logic         reload,
  output logic [W-1:0] cur
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= '0;
    else if (load_en) cur <= load_val;
    else if (step)    cur <= reload ? base_val : cur + W'(1);
  end
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] base_val,
  input  logic         step,
  input  logic         autoinit,
  output logic [W-1:0] cur,
  output logic         at_zero
);
  assign at_zero = (cur == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= '0;
    else if (load_en) cur <= load_val;
    else if (step)    cur <= (at_zero && autoinit) ? base_val : cur - W'(1);
  end
endmodule

// File: rtl/dma_bus_map.sv
module dma_bus_map #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_MODE = 1'b0,
  localparam int BUS_W    = ADDR_W + PAGE_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] ofs,
  output logic [BUS_W-1:0]  bus
);
  generate
    if (WORD_MODE) begin : g_word
      logic unused_page_lsb;
      assign unused_page_lsb = page[0];
      assign bus = {page[PAGE_W-1:1], ofs, 1'b0};
    end else begin : g_byte
      assign bus = {page, ofs};
    end
  endgenerate
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_MODE = 1'b0,
  localparam int BUS_W    = ADDR_W + PAGE_W,
  localparam int PAGE_LO  = WORD_MODE ? ADDR_W + 1 : ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  output logic [BUS_W-1:0]  bus_addr,
  output logic [ADDR_W-1:0] residue,
  output logic              tc
);
  import dma_chan_pkg::*;

  cfg_sel_e          sel;
  logic [ADDR_W-1:0] base_ofs, base_cnt, cur_ofs;
  logic [PAGE_W-1:0] page_q;
  logic              auto_q, masked_q, hs, cnt_zero, reload;
  logic              wr_ofs, wr_cnt, wr_page, wr_mode;

  assign sel     = cfg_sel_e'(cfg_sel);
  assign wr_ofs  = cfg_we && (sel == SEL_OFFSET);
  assign wr_cnt  = cfg_we && (sel == SEL_COUNT);
  assign wr_page = cfg_we && (sel == SEL_PAGE);
  assign wr_mode = cfg_we && (sel == SEL_MODE);

  assign xfer_ready = !masked_q;
  assign hs         = xfer_valid && xfer_ready;
  assign tc         = hs && cnt_zero;
  assign reload     = tc && auto_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_ofs <= '0;
      base_cnt <= '0;
      page_q   <= '0;
      auto_q   <= 1'b0;
    end else begin
      if (wr_ofs)  base_ofs <= cfg_data;
      if (wr_cnt)  base_cnt <= cfg_data;
      if (wr_page) page_q   <= cfg_data[PAGE_W-1:0];
      if (wr_mode) auto_q   <= cfg_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           masked_q <= 1'b1;
    else if ((tc && !auto_q) || mask_set) masked_q <= 1'b1;
    else if (mask_clr)                    masked_q <= 1'b0;
  end

  dma_offset_unit #(.W(ADDR_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .load_en(wr_ofs), .load_val(cfg_data),
    .base_val(base_ofs), .step(hs), .reload(reload), .cur(cur_ofs)
  );

  dma_count_unit #(.W(ADDR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_en(wr_cnt), .load_val(cfg_data),
    .base_val(base_cnt), .step(hs), .autoinit(auto_q),
    .cur(residue), .at_zero(cnt_zero)
  );

  dma_bus_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_MODE(WORD_MODE)) u_map (
    .page(page_q), .ofs(cur_ofs), .bus(bus_addr)
  );

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !cfg_we && residue != '0)
      |=> residue == $past(residue) - ADDR_W'(1));

  // R6
  tc_only_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (xfer_valid && xfer_ready && residue == '0));

  // R7
  self_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !auto_q) |=> !xfer_ready);

  // R9
  masked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ready && !cfg_we) |=> ($stable(residue) && $stable(bus_addr)));

  // R5
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !cfg_we)
      |=> $stable(bus_addr[BUS_W-1:PAGE_LO]));

  // R12
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set |=> !xfer_ready);
endmodule

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;
  localparam logic [2:0] OP_OFS = 3'd0, OP_CNT = 3'd1, OP_PAGE = 3'd2,
                         OP_MODE = 3'd3, OP_UNMASK = 3'd4, OP_MASK = 3'd5,
                         OP_XFER = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] data;
    logic [23:0] addr;
    logic [15:0] res;
    logic        tc;
    logic        rdy;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{OP_PAGE,   16'h0012, 24'h120000, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2
    '{OP_OFS,    16'hFFFE, 24'h12FFFE, 16'h0000, 1'b0, 1'b0, 4'd10}, // R10
    '{OP_CNT,    16'h0002, 24'h12FFFE, 16'h0002, 1'b0, 1'b0, 4'd10}, // R10
    '{OP_UNMASK, 16'h0000, 24'h12FFFE, 16'h0002, 1'b0, 1'b1, 4'd12}, // R12
    '{OP_XFER,   16'h0000, 24'h12FFFF, 16'h0001, 1'b0, 1'b1, 4'd4},  // R4
    '{OP_XFER,   16'h0000, 24'h120000, 16'h0000, 1'b0, 1'b1, 4'd5},  // R5 wrap
    '{OP_XFER,   16'h0000, 24'h120001, 16'hFFFF, 1'b1, 1'b0, 4'd7},  // R7, R6
    '{OP_XFER,   16'h0000, 24'h120001, 16'hFFFF, 1'b0, 1'b0, 4'd9},  // R9
    '{OP_MODE,   16'h0001, 24'h120001, 16'hFFFF, 1'b0, 1'b0, 4'd10},
    '{OP_OFS,    16'h0100, 24'h120100, 16'hFFFF, 1'b0, 1'b0, 4'd10},
    '{OP_CNT,    16'h0001, 24'h120100, 16'h0001, 1'b0, 1'b0, 4'd10},
    '{OP_UNMASK, 16'h0000, 24'h120100, 16'h0001, 1'b0, 1'b1, 4'd12},
    '{OP_XFER,   16'h0000, 24'h120101, 16'h0000, 1'b0, 1'b1, 4'd4},
    '{OP_XFER,   16'h0000, 24'h120100, 16'h0001, 1'b1, 1'b1, 4'd8},  // R8 reload
    '{OP_XFER,   16'h0000, 24'h120101, 16'h0000, 1'b0, 1'b1, 4'd11}, // R11
    '{OP_MASK,   16'h0000, 24'h120101, 16'h0000, 1'b0, 1'b0, 4'd12},
    '{OP_XFER,   16'h0000, 24'h120101, 16'h0000, 1'b0, 1'b0, 4'd9}
  };

  logic clk = 1'b0;
  logic rst_n, cfg_we, mask_set, mask_clr, xfer_valid;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_data;
  logic        rdy_b, tc_b, rdy_w, tc_w;
  logic [23:0] addr_b, addr_w;
  logic [15:0] res_b, res_w;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  dma_chan_engine #(.WORD_MODE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .mask_set(mask_set), .mask_clr(mask_clr),
    .xfer_valid(xfer_valid), .xfer_ready(rdy_b), .bus_addr(addr_b),
    .residue(res_b), .tc(tc_b)
  );

  dma_chan_engine #(.WORD_MODE(1'b1)) uut_w (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .mask_set(mask_set), .mask_clr(mask_clr),
    .xfer_valid(xfer_valid), .xfer_ready(rdy_w), .bus_addr(addr_w),
    .residue(res_w), .tc(tc_w)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic idle();
    cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    mask_set = 0; mask_clr = 0; xfer_valid = 0;
  endtask

  // Applies one operation for one cycle; returns tc seen before the edge.
  task automatic apply(input logic [2:0] op, input logic [15:0] d, output logic tcs);
    @(negedge clk);
    idle();
    case (op)
      OP_UNMASK: mask_clr = 1;
      OP_MASK:   mask_set = 1;
      OP_XFER:   xfer_valid = 1;
      default: begin cfg_we = 1; cfg_sel = op[1:0]; cfg_data = d; end
    endcase
    #1 tcs = tc_b;
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic t;
    int tcs, tc_at;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state, both variants
    chk("R1", {rdy_b, tc_b, res_b, addr_b}, 64'h0);
    chk("R1", {rdy_w, tc_w, res_w, addr_w}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].data, t);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i),
          {addr_b, res_b, t, rdy_b},
          {VEC[i].addr, VEC[i].res, VEC[i].tc, VEC[i].rdy});
    end

    // R3 word mode mapping, page bit 0 ignored
    apply(OP_PAGE, 16'h0035, t);
    apply(OP_OFS, 16'h8001, t);
    apply(OP_CNT, 16'h0003, t);
    chk("R3 word addr", addr_w, 24'h350002);
    chk("R3 byte residue", (32'(res_w) + 1) << 1, 8);
    apply(OP_UNMASK, 0, t);
    apply(OP_XFER, 0, t);
    chk("R3 word step", addr_w, 24'h350004);
    // R5 word wrap stays inside the 128K window
    apply(OP_PAGE, 16'h0034, t);
    apply(OP_OFS, 16'hFFFF, t);
    chk("R5 word pre-wrap", addr_w, 24'h35FFFE);
    apply(OP_XFER, 0, t);
    chk("R5 word wrap", addr_w, 24'h340000);
    chk("R2 byte page 0x34", addr_b, 24'h340000);

    // R11 full count 0xFFFF gives 65536 transfers, tc on the last
    apply(OP_MODE, 16'h0000, t);
    apply(OP_CNT, 16'hFFFF, t);
    apply(OP_OFS, 16'h0000, t);
    apply(OP_UNMASK, 0, t);
    tcs = 0; tc_at = -1;
    @(negedge clk);
    xfer_valid = 1;
    for (int i = 0; i < 65536; i++) begin
      #1;
      if (tc_b) begin tcs++; tc_at = i; end
      @(negedge clk);
    end
    xfer_valid = 0;
    #1;
    chk("R11 tc count", tcs, 1);
    chk("R11 tc position", tc_at, 65535);
    chk("R7 masked after full run", {rdy_b, res_b}, {1'b0, 16'hFFFF});
    chk("R5 byte wrap after 65536", addr_b, 24'h340000);

    summary();
    $finish;
  end
endmodule